// File: doc/BRIEF.md
# GPIO Bank with Interrupt Cause Logic

A bank of general-purpose I/O lines behind a small 32-bit register port (byte address, write strobe, write data, registered read data). Software sets, for each line, an output value, a direction, a blink enable and an input polarity. The pins pass through a two-flop synchroniser and are then XORed with the polarity bits to form the data-in value. Every interrupt decision is made on this corrected value. A single rising-edge detector therefore covers rising, falling and both-edge triggers: software swaps the polarity bit to catch the other edge.

Level sources are data-in gated by a level mask and are not latched. Edge events set bits in a cause register. That register is gated by an edge mask. Software acknowledges a line by writing a zero to its cause bit. The pending vector is ORed in groups of eight lines, and the result drives one registered interrupt output per group.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the edge cause, edge mask, level mask, output, blink and polarity registers read 0, the direction register reads all ones (every line an input), and all interrupt outputs and `pin_oe` are 0.
- R2: Registers sit at byte offsets 0x00 output, 0x04 direction, 0x08 blink, 0x0C polarity, 0x10 data-in, 0x14 edge cause, 0x18 edge mask, 0x1C level mask. The writable ones read back the value written. `reg_rdata` shows the register addressed one clock earlier.
- R3: `pin_oe[i]` is 1 exactly when direction bit i is 0. With blink off, `pin_out` equals the output register.
- R4: Data-in reads the pin value after two synchroniser flops, XORed with the polarity register. Polarity 1 inverts a line.
- R5: The level source is data-in AND level mask, with no latching. An interrupt output drops once the line returns low.
- R6: An edge cause bit is set on a 0-to-1 change of the corrected data-in. The bit is visible in the register one clock after data-in changes. A 1-to-0 change sets nothing.
- R7: Writing the edge cause register clears each bit written as 0 and keeps each bit written as 1.
- R8: If a new edge and a clearing write hit the same cause bit in one cycle, the bit ends up set.
- R9: Cause bits latch even while the edge mask is 0. Setting the mask later raises the interrupt.
- R10: Line i contributes only to interrupt output i/8. Each output is registered, so it follows the pending vector with one clock delay.
- R11: When an output line has blink enabled, the pin shows the output bit ANDed with a free-running square wave whose half period is BLINK_DIV clocks.
- R12: Reads of unmapped addresses return 0. Writes to unmapped addresses, and writes to the data-in register, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | N_LINES | Write data |
| reg_rdata | output | N_LINES | Registered read data |
| pin_in | input | N_LINES | Raw pin inputs |
| pin_out | output | N_LINES | Pin drive values |
| pin_oe | output | N_LINES | Pin output enables |
| irq_out | output | N_LINES/GRP_SIZE | One interrupt per group of eight lines |

## Verification
Single lines are raised in different groups (lines 8, 31, 16, 0, 1). This shows that a line reaches only its own interrupt output and that level sources follow the pin without memory. The polarity bit is toggled, and one line is pulsed both ways with inverted polarity. This separates edge detection on the corrected value from detection on the raw pin. The cause register is read in the cycle before an edge lands and in the cycle after, which pins down its latency. One acknowledge write is timed to collide with a new edge, which exposes a clear-over-set priority error. Blink is run on a line whose output is 1 and on a line whose output is 0, over a whole number of periods, and the high time is counted.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  typedef enum logic [3:0] {
    RS_OUT, RS_DIR, RS_BLINK, RS_POL, RS_DIN,
    RS_CAUSE, RS_EMASK, RS_LMASK, RS_NONE
  } reg_sel_e;

  // byte offsets: software decodes these, so they are fixed
  function automatic reg_sel_e decode_addr(input logic [31:0] a);
    case (a)
      32'h00:  return RS_OUT;
      32'h04:  return RS_DIR;
      32'h08:  return RS_BLINK;
      32'h0C:  return RS_POL;
      32'h10:  return RS_DIN;
      32'h14:  return RS_CAUSE;
      32'h18:  return RS_EMASK;
      32'h1C:  return RS_LMASK;
      default: return RS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
`timescale 1ns/1ps
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_edge_cause.sv
`timescale 1ns/1ps
module gpio_edge_cause #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  input  logic         ack_en,
  input  logic [W-1:0] ack_keep,
  output logic [W-1:0] cause
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;
  logic [W-1:0] kept;

  assign rise = level & ~prev_q;
  assign kept = ack_en ? (cause & ack_keep) : cause;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      cause  <= '0;
    end else begin
      prev_q <= level;
      cause  <= kept | rise;   // a fresh edge beats the acknowledge
    end
  end
endmodule

// File: rtl/gpio_blink_div.sv
`timescale 1ns/1ps
module gpio_blink_div #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic phase
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      phase <= ~phase;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int N_LINES   = 32,
  parameter int GRP_SIZE  = 8,
  parameter int ADDR_W    = 8,
  parameter int BLINK_DIV = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic                          reg_wr,
  input  logic [N_LINES-1:0]            reg_wdata,
  output logic [N_LINES-1:0]            reg_rdata,
  input  logic [N_LINES-1:0]            pin_in,
  output logic [N_LINES-1:0]            pin_out,
  output logic [N_LINES-1:0]            pin_oe,
  output logic [N_LINES/GRP_SIZE-1:0]   irq_out
);
  localparam int NGRP = N_LINES / GRP_SIZE;

  logic [N_LINES-1:0] out_q, dir_q, blink_q, pol_q, emask_q, lmask_q;
  logic [N_LINES-1:0] sync_w, data_in_w, cause_q, pending_w;
  logic               phase_w;
  reg_sel_e           sel_w;

  assign sel_w = decode_addr(32'(reg_addr));

  gpio_sync2 #(.W(N_LINES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(sync_w)
  );

  assign data_in_w = sync_w ^ pol_q;

  gpio_edge_cause #(.W(N_LINES)) u_cause (
    .clk(clk), .rst(rst), .level(data_in_w),
    .ack_en(reg_wr && (sel_w == RS_CAUSE)),
    .ack_keep(reg_wdata), .cause(cause_q)
  );

  gpio_blink_div #(.DIV(BLINK_DIV)) u_blink (
    .clk(clk), .rst(rst), .phase(phase_w)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else if (reg_wr) begin
      case (sel_w)
        RS_OUT:   out_q   <= reg_wdata;
        RS_DIR:   dir_q   <= reg_wdata;
        RS_BLINK: blink_q <= reg_wdata;
        RS_POL:   pol_q   <= reg_wdata;
        RS_EMASK: emask_q <= reg_wdata;
        RS_LMASK: lmask_q <= reg_wdata;
        default:  ;
      endcase
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (sel_w)
        RS_OUT:   reg_rdata <= out_q;
        RS_DIR:   reg_rdata <= dir_q;
        RS_BLINK: reg_rdata <= blink_q;
        RS_POL:   reg_rdata <= pol_q;
        RS_DIN:   reg_rdata <= data_in_w;
        RS_CAUSE: reg_rdata <= cause_q;
        RS_EMASK: reg_rdata <= emask_q;
        RS_LMASK: reg_rdata <= lmask_q;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  assign pin_oe    = ~dir_q;
  assign pin_out   = out_q & (~blink_q | {N_LINES{phase_w}});
  assign pending_w = (data_in_w & lmask_q) | (cause_q & emask_q);

  for (genvar g = 0; g < NGRP; g++) begin : g_irq
    always_ff @(posedge clk) begin
      if (rst) irq_out[g] <= 1'b0;
      else     irq_out[g] <= |pending_w[g*GRP_SIZE +: GRP_SIZE];
    end
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
`timescale 1ns/1ps
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int NGRP    = 4,
  parameter int ADDR_W  = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic                reg_wr,
  input logic [N_LINES-1:0]  reg_wdata,
  input logic [NGRP-1:0]     irq_out,
  input logic [N_LINES-1:0]  din,
  input logic [N_LINES-1:0]  cause_q,
  input logic [N_LINES-1:0]  emask_q,
  input logic [N_LINES-1:0]  lmask_q,
  input logic [N_LINES-1:0]  dir_q
);
  logic ack_w, unmapped_w;
  assign ack_w      = reg_wr && (decode_addr(32'(reg_addr)) == RS_CAUSE);
  assign unmapped_w = reg_wr && (decode_addr(32'(reg_addr)) == RS_NONE);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    // R6
    edge_sets_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(din[i]) |=> cause_q[i]);
    // R7
    cause_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (cause_q[i] && !(ack_w && !reg_wdata[i])) |=> cause_q[i]);
  end

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (lmask_q == '0 && emask_q == '0) |=> (irq_out == '0));

  // R12
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    unmapped_w |=> ($stable(dir_q) && $stable(emask_q) && $stable(lmask_q)));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .N_LINES(N_LINES), .NGRP(NGRP), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .irq_out(irq_out), .din(data_in_w),
  .cause_q(cause_q), .emask_q(emask_q), .lmask_q(lmask_q), .dir_q(dir_q)
);

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
  localparam int BDIV = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, pin_out, pin_oe;
  logic [31:0] pin_in = '0;
  logic [3:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  gpio_irq_bank #(.N_LINES(32), .GRP_SIZE(8), .ADDR_W(8), .BLINK_DIV(BDIV)) u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  // scoreboard: sel 0 rdata, 1 irq, 2 pin_out, 3 pin_oe, 4 bench value
  typedef struct {
    string       tag;
    int          sel;
    logic [31:0] exp;
    logic [31:0] act;
  } item_t;
  item_t sbq[$];
  event  smp;

  always begin
    @(smp);
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = sbq.pop_front();
      case (it.sel)
        0: got = reg_rdata;
        1: got = {28'h0, irq_out};
        2: got = pin_out;
        3: got = pin_oe;
        default: got = it.act;
      endcase
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, got, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_v(int sel, logic [31:0] e, string tag, logic [31:0] a = '0);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = e; it.act = a;
    sbq.push_back(it);
    -> smp;
    #1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    reg_addr = a;
    tick();
    expect_v(0, e, tag);
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int ones0, ones1, ones4;
    ticks(3);
    rst = 1'b0;
    // R1 reset state
    expect_v(1, 0, "R1 irq");
    expect_v(3, 0, "R1 pin_oe");
    rd(8'h04, 32'hFFFF_FFFF, "R1 dir");
    rd(8'h14, 0, "R1 cause");
    rd(8'h18, 0, "R1 emask");
    rd(8'h1C, 0, "R1 lmask");
    // R2 readback
    wr(8'h00, 32'hA5A5_0F0F);
    rd(8'h00, 32'hA5A5_0F0F, "R2 out");
    wr(8'h1C, 32'h1234_5678);
    rd(8'h1C, 32'h1234_5678, "R2 lmask");
    wr(8'h1C, 0);
    // R3 direction
    wr(8'h04, 32'hFFFF_0000);
    expect_v(3, 32'h0000_FFFF, "R3 pin_oe");
    expect_v(2, 32'hA5A5_0F0F, "R3 pin_out");
    // R4 sync and polarity
    pin_in = 32'h8000_0001;
    ticks(2);
    rd(8'h10, 32'h8000_0001, "R4 din");
    wr(8'h0C, 32'h3);
    rd(8'h10, 32'h8000_0002, "R4 din inverted");
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h8000_0002, "R12 din write ignored");
    wr(8'h0C, 0);
    pin_in = 0;
    ticks(4);
    wr(8'h14, 0);
    rd(8'h14, 0, "R7 clear all");
    // R5 level, group 1
    wr(8'h1C, 32'h0000_0100);
    pin_in = 32'h0000_0100;
    ticks(2);
    expect_v(1, 0, "R10 irq latency");
    tick();
    expect_v(1, 32'h2, "R5 level irq");
    pin_in = 0;
    ticks(3);
    expect_v(1, 0, "R5 level not latched");
    // R10 group 3
    wr(8'h1C, 32'h8000_0000);
    pin_in = 32'h8000_0000;
    ticks(3);
    expect_v(1, 32'h8, "R10 line 31 group");
    pin_in = 0;
    wr(8'h1C, 0);
    ticks(3);
    wr(8'h14, 0);
    rd(8'h14, 0, "R7 clear");
    // R6 edge on corrected value
    wr(8'h0C, 32'h0001_0000);
    ticks(2);
    wr(8'h14, 0);
    rd(8'h14, 0, "R7 clear pol edge");
    pin_in = 32'h0001_0000;
    ticks(3);
    rd(8'h14, 0, "R6 no event on corrected fall");
    pin_in = 0;
    ticks(2);
    rd(8'h14, 0, "R6 cause before edge lands");
    rd(8'h14, 32'h0001_0000, "R6 cause after edge");
    expect_v(1, 0, "R9 masked");
    wr(8'h18, 32'h0001_0000);
    tick();
    expect_v(1, 32'h4, "R9 unmask raises");
    // R7 selective ack
    pin_in = 32'h1;
    ticks(3);
    rd(8'h14, 32'h0001_0001, "R7 two causes");
    wr(8'h14, 32'hFFFE_FFFF);
    rd(8'h14, 32'h0000_0001, "R7 single ack");
    expect_v(1, 0, "R7 irq dropped");
    // R8 set beats clear
    pin_in = 32'h3;
    ticks(2);
    wr(8'h14, 0);
    rd(8'h14, 32'h0000_0002, "R8 set wins");
    // R11 blink
    wr(8'h08, 32'h11);
    ones0 = 0; ones1 = 0; ones4 = 0;
    for (int k = 0; k < 4 * BDIV; k++) begin
      tick();
      ones0 += int'(pin_out[0]);
      ones1 += int'(pin_out[1]);
      ones4 += int'(pin_out[4]);
    end
    expect_v(4, 2 * BDIV, "R11 blink high time", ones0);
    expect_v(4, 4 * BDIV, "R11 no blink steady", ones1);
    expect_v(4, 0, "R11 blink with out 0", ones4);
    // R12 unmapped
    rd(8'h20, 0, "R12 read 0x20");
    rd(8'hFC, 0, "R12 read 0xFC");
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h00, 32'hA5A5_0F0F, "R12 out kept");
    rd(8'h18, 32'h0001_0000, "R12 emask kept");
    rd(8'h04, 32'hFFFF_0000, "R12 dir kept");
    rd(8'h08, 32'h11, "R12 blink kept");
    done = 1;
    #4;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule